// File: doc/BRIEF.md
# Priority Crossbar Pin Assigner

This block places a set of internal digital peripheral signals onto a bank of general-purpose pins. The default bank is three byte-wide ports, 24 pins in all. Each peripheral function is switched on by a bit in one of two 8-bit enable registers. The enabled functions are then handed out in a fixed priority order. Each enabled signal takes the lowest-numbered pin that is neither skipped nor already taken. A per-pin skip mask lets a system reserve pins, for example for analog use, without disturbing the rest of the order. A pin that no peripheral claims stays a general-purpose output and follows its port latch bit.

Each pin also has an output-mode bit, push-pull or open-drain, and an input-mode bit, analog or digital. An analog pin is never driven. The synchronised pin levels are always presented on a read-back bus, whatever the routing. Peripheral input signals are routed back from their assigned pins. A signal that found no pin reads as logic 1, the idle level.

All configuration inputs are captured into registers at the clock edge. The pin assignment is then decoded combinationally from those registered values, while the peripheral data paths stay combinational.

Top module: `prio_xbar`

## Requirements
- R1: Signal slots have a fixed priority from 0 upward, and an enabled slot is always placed before any later one:
  - 0 UART transmit, 1 UART receive.
  - 2 to 5 SPI clock, master-in, master-out and select.
  - 6 SMBus data, 7 SMBus clock.
  - 8 comparator 0 output, 9 comparator 1 output, 10 system clock output.
  - 11 up to 10+NPCA for the PCA channels.
  - Then the timer 0 input and the timer 1 input.

  Enabled slots take the unskipped pins in ascending pin order (pin index = port*8 + bit), with no gaps.
- R2: Enable register A uses bit 0 for UART, bit 1 for SPI, bit 2 for SMBus, bit 3 for comparator 0, bit 4 for comparator 1 and bit 5 for the clock output. Enable register B uses bits 2:0 as the number of PCA channels (values above NPCA act as NPCA), bit 3 for timer 0 and bit 4 for timer 1. All other bits have no effect.
- R3: A pin whose skip bit is 1 is never given to a slot.
- R4: An enabled slot left without a free unskipped pin is unassigned, and its per_in bit reads 1. The per_in bit of a disabled slot also reads 1.
- R5: An assigned pin takes its level and output enable from its slot's per_out and per_oe bits, and that slot's per_in bit follows the pin's pin_in level.
- R6: An unassigned pin is a driven output whose level is its latch bit.
- R7: With the open-drain bit set, pin_out is 0 and pin_oe is 1 only when the selected level is 0. With the bit clear, pin_out carries the level and pin_oe carries the selected enable.
- R8: With the analog bit set, pin_oe is 0 whatever the routing or latch.
- R9: port_rd equals pin_in delayed by SYNC_STAGES clock edges, whatever the configuration.
- R10: A configuration change takes effect at the first rising clock edge after it is applied, and not before.
- R11: After reset all configuration is clear except the latches, which are all 1. So every pin drives 1, every per_in bit is 1 and port_rd is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en_a | input | 8 | Function enable register A |
| cfg_en_b | input | 8 | Function enable register B |
| cfg_skip | input | 24 | Per-pin skip mask |
| cfg_odrain | input | 24 | Per-pin open-drain select |
| cfg_analog | input | 24 | Per-pin analog select |
| cfg_latch | input | 24 | Port latch values |
| per_out | input | 19 | Peripheral output level per slot |
| per_oe | input | 19 | Peripheral output enable per slot |
| per_in | output | 19 | Routed pin level per slot |
| pin_in | input | 24 | Pad input levels |
| pin_out | output | 24 | Pad output levels |
| pin_oe | output | 24 | Pad output enables |
| port_rd | output | 24 | Synchronised pin read-back |

## Verification
The bench targets packing around skipped pins. A design that counts skipped pins in the scan would leave a hole or put a signal on a reserved pin. It also targets the overflow edge, where the lowest-priority functions run out of pins: a wrong bound would alias those functions onto pin 0 or leave their inputs floating low. It checks the PCA count clamp and the analog override combined with open-drain, where a wrong gating order would drive an analog pin. It also checks the one-edge configuration latency, which shows up as an output changing early or a cycle late.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
   // fixed slot layout; PCA channels follow the clock output
   localparam int SL_TX    = 0;
   localparam int SL_RX    = 1;
   localparam int SL_SCK   = 2;
   localparam int SL_NSS   = 5;
   localparam int SL_SDA   = 6;
   localparam int SL_SCL   = 7;
   localparam int SL_CMP0  = 8;
   localparam int SL_CMP1  = 9;
   localparam int SL_CLKO  = 10;
   localparam int SL_PCA0  = 11;
   localparam int PCA_MAX  = 7;

   function automatic int slot_count(int npca);
      return SL_PCA0 + npca + 2;
   endfunction

   function automatic int slot_t0(int npca);
      return SL_PCA0 + npca;
   endfunction

   typedef struct packed {
      logic [1:0] rsvd;
      logic       clko;
      logic       cmp1;
      logic       cmp0;
      logic       smb;
      logic       spi;
      logic       uart;
   } en_a_t;

   typedef struct packed {
      logic [2:0] rsvd;
      logic       t1;
      logic       t0;
      logic [2:0] pca_cnt;
   } en_b_t;
endpackage

// File: rtl/xbar_cfg_reg.sv
module xbar_cfg_reg #(
   parameter int NPIN = 24,
   parameter logic [NPIN-1:0] LATCH_RST = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [7:0]      en_a_d,
   input  logic [7:0]      en_b_d,
   input  logic [NPIN-1:0] skip_d,
   input  logic [NPIN-1:0] odrain_d,
   input  logic [NPIN-1:0] analog_d,
   input  logic [NPIN-1:0] latch_d,
   output logic [7:0]      en_a_q,
   output logic [7:0]      en_b_q,
   output logic [NPIN-1:0] skip_q,
   output logic [NPIN-1:0] odrain_q,
   output logic [NPIN-1:0] analog_q,
   output logic [NPIN-1:0] latch_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_a_q   <= '0;
         en_b_q   <= '0;
         skip_q   <= '0;
         odrain_q <= '0;
         analog_q <= '0;
         latch_q  <= LATCH_RST;
      end else begin
         en_a_q   <= en_a_d;
         en_b_q   <= en_b_d;
         skip_q   <= skip_d;
         odrain_q <= odrain_d;
         analog_q <= analog_d;
         latch_q  <= latch_d;
      end
   end
endmodule

// File: rtl/xbar_slot_en.sv
module xbar_slot_en
   import xbar_pkg::*;
#(
   parameter int NPCA = 6,
   parameter int NSIG = 19
) (
   input  logic [7:0]      en_a,
   input  logic [7:0]      en_b,
   output logic [NSIG-1:0] slot_en
);
   localparam int T0 = slot_t0(NPCA);

   en_a_t    a;
   en_b_t    b;
   logic [3:0] lim;

   assign a   = en_a_t'(en_a);
   assign b   = en_b_t'(en_b);
   assign lim = ({1'b0, b.pca_cnt} > 4'(NPCA)) ? 4'(NPCA) : {1'b0, b.pca_cnt};

   assign slot_en[SL_TX]            = a.uart;
   assign slot_en[SL_RX]            = a.uart;
   assign slot_en[SL_NSS:SL_SCK]    = {4{a.spi}};
   assign slot_en[SL_SDA]           = a.smb;
   assign slot_en[SL_SCL]           = a.smb;
   assign slot_en[SL_CMP0]          = a.cmp0;
   assign slot_en[SL_CMP1]          = a.cmp1;
   assign slot_en[SL_CLKO]          = a.clko;
   assign slot_en[T0]               = b.t0;
   assign slot_en[T0+1]             = b.t1;

   for (genvar i = 0; i < NPCA; i++) begin : g_pca
      assign slot_en[SL_PCA0+i] = (4'(i) < lim);
   end
endmodule

// File: rtl/xbar_rank_decode.sv
module xbar_rank_decode #(
   parameter int NPIN = 24,
   parameter int NSIG = 19,
   parameter int PW   = 5,
   parameter int SW   = 5
) (
   input  logic [NSIG-1:0]          slot_en,
   input  logic [NPIN-1:0]          skip,
   output logic [NPIN-1:0]          owner_vld,
   output logic [NPIN-1:0][SW-1:0]  owner_idx,
   output logic [NSIG-1:0]          slot_vld,
   output logic [NSIG-1:0][PW-1:0]  slot_pin
);
   localparam int BIG = (NPIN > NSIG) ? NPIN : NSIG;
   localparam int RW  = $clog2(BIG + 1);

   logic [NPIN-1:0][RW-1:0] pin_rank;
   logic [NSIG-1:0][RW-1:0] slot_rank;
   logic [RW-1:0]           free_cnt;

   // rank of each pin among unskipped pins
   always_comb begin
      logic [RW-1:0] acc;
      acc = '0;
      for (int p = 0; p < NPIN; p++) begin
         pin_rank[p] = acc;
         acc = acc + RW'(!skip[p]);
      end
      free_cnt = acc;
   end

   // rank of each slot among enabled slots
   always_comb begin
      logic [RW-1:0] acc;
      acc = '0;
      for (int s = 0; s < NSIG; s++) begin
         slot_rank[s] = acc;
         acc = acc + RW'(slot_en[s]);
      end
   end

   // pin view: which slot landed here
   always_comb begin
      owner_vld = '0;
      owner_idx = '0;
      for (int p = 0; p < NPIN; p++) begin
         for (int s = 0; s < NSIG; s++) begin
            if (!skip[p] && slot_en[s] && (slot_rank[s] == pin_rank[p])) begin
               owner_vld[p] = 1'b1;
               owner_idx[p] = SW'(s);
            end
         end
      end
   end

   // slot view: where each slot landed
   always_comb begin
      for (int s = 0; s < NSIG; s++) begin
         slot_vld[s] = slot_en[s] && (slot_rank[s] < free_cnt);
         slot_pin[s] = '0;
         for (int p = 0; p < NPIN; p++) begin
            if (!skip[p] && slot_en[s] && (slot_rank[s] == pin_rank[p]))
               slot_pin[s] = PW'(p);
         end
      end
   end
endmodule

// File: rtl/xbar_pin_cell.sv
module xbar_pin_cell #(
   parameter int NSIG = 19,
   parameter int SW   = 5
) (
   input  logic            own_vld,
   input  logic [SW-1:0]   own_idx,
   input  logic [NSIG-1:0] per_out,
   input  logic [NSIG-1:0] per_oe,
   input  logic            latch,
   input  logic            odrain,
   input  logic            analog,
   output logic            pad_out,
   output logic            pad_oe
);
   logic lvl, en;

   always_comb begin
      if (own_vld) begin
         lvl = per_out[own_idx];
         en  = per_oe[own_idx];
      end else begin
         lvl = latch;
         en  = 1'b1;
      end
   end

   assign pad_out = odrain ? 1'b0 : lvl;
   assign pad_oe  = analog ? 1'b0 : (odrain ? (en & ~lvl) : en);
endmodule

// File: rtl/xbar_rd_sync.sv
module xbar_rd_sync #(
   parameter int NPIN   = 24,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] d,
   output logic [NPIN-1:0] q
);
   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_sync
      logic [STAGES-1:0][NPIN-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sr <= '0;
         end else begin
            sr[0] <= d;
            for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
         end
      end
      assign q = sr[STAGES-1];
   end
endmodule

// File: rtl/prio_xbar.sv
module prio_xbar
   import xbar_pkg::*;
#(
   parameter int NPORT       = 3,
   parameter int PORT_W      = 8,
   parameter int NPCA        = 6,
   parameter int SYNC_STAGES = 2,
   parameter int NPIN        = NPORT * PORT_W,
   parameter int NSIG        = 19,
   parameter logic [NPIN-1:0] LATCH_RST = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [7:0]      cfg_en_a,
   input  logic [7:0]      cfg_en_b,
   input  logic [NPIN-1:0] cfg_skip,
   input  logic [NPIN-1:0] cfg_odrain,
   input  logic [NPIN-1:0] cfg_analog,
   input  logic [NPIN-1:0] cfg_latch,
   input  logic [NSIG-1:0] per_out,
   input  logic [NSIG-1:0] per_oe,
   output logic [NSIG-1:0] per_in,
   input  logic [NPIN-1:0] pin_in,
   output logic [NPIN-1:0] pin_out,
   output logic [NPIN-1:0] pin_oe,
   output logic [NPIN-1:0] port_rd
);
   localparam int PW = (NPIN > 1) ? $clog2(NPIN) : 1;
   localparam int SW = $clog2(NSIG);

   if (NPCA < 1 || NPCA > PCA_MAX) begin : g_bad_pca
      $error("NPCA out of range");
   end
   if (NSIG != slot_count(NPCA)) begin : g_bad_nsig
      $error("NSIG must match slot_count(NPCA)");
   end
   if (NPIN != NPORT * PORT_W) begin : g_bad_npin
      $error("NPIN must equal NPORT*PORT_W");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES out of range");
   end

   logic [7:0]      en_a_q, en_b_q;
   logic [NPIN-1:0] skip_q, odrain_q, analog_q, latch_q;
   logic [NSIG-1:0] slot_en;
   logic [NPIN-1:0]          owner_vld;
   logic [NPIN-1:0][SW-1:0]  owner_idx;
   logic [NSIG-1:0]          slot_vld;
   logic [NSIG-1:0][PW-1:0]  slot_pin;

   xbar_cfg_reg #(.NPIN(NPIN), .LATCH_RST(LATCH_RST)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_a_d   (cfg_en_a),
      .en_b_d   (cfg_en_b),
      .skip_d   (cfg_skip),
      .odrain_d (cfg_odrain),
      .analog_d (cfg_analog),
      .latch_d  (cfg_latch),
      .en_a_q   (en_a_q),
      .en_b_q   (en_b_q),
      .skip_q   (skip_q),
      .odrain_q (odrain_q),
      .analog_q (analog_q),
      .latch_q  (latch_q)
   );

   xbar_slot_en #(.NPCA(NPCA), .NSIG(NSIG)) u_slot (
      .en_a    (en_a_q),
      .en_b    (en_b_q),
      .slot_en (slot_en)
   );

   xbar_rank_decode #(.NPIN(NPIN), .NSIG(NSIG), .PW(PW), .SW(SW)) u_rank (
      .slot_en   (slot_en),
      .skip      (skip_q),
      .owner_vld (owner_vld),
      .owner_idx (owner_idx),
      .slot_vld  (slot_vld),
      .slot_pin  (slot_pin)
   );

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      xbar_pin_cell #(.NSIG(NSIG), .SW(SW)) u_cell (
         .own_vld (owner_vld[p]),
         .own_idx (owner_idx[p]),
         .per_out (per_out),
         .per_oe  (per_oe),
         .latch   (latch_q[p]),
         .odrain  (odrain_q[p]),
         .analog  (analog_q[p]),
         .pad_out (pin_out[p]),
         .pad_oe  (pin_oe[p])
      );
   end

   for (genvar s = 0; s < NSIG; s++) begin : g_back
      assign per_in[s] = slot_vld[s] ? pin_in[slot_pin[s]] : 1'b1;
   end

   xbar_rd_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (port_rd)
   );
endmodule

// File: rtl/prio_xbar_chk.sv
module prio_xbar_chk #(
   parameter int NPIN = 24,
   parameter int NSIG = 19,
   parameter int PW   = 5
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NPIN-1:0]          cfg_odrain,
   input logic [NPIN-1:0]          cfg_analog,
   input logic [NPIN-1:0]          pin_out,
   input logic [NPIN-1:0]          pin_oe,
   input logic [NSIG-1:0]          per_in,
   input logic [NPIN-1:0]          skip_q,
   input logic [NSIG-1:0]          slot_vld,
   input logic [NSIG-1:0][PW-1:0]  slot_pin
);
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   logic order_bad;
   always_comb begin
      order_bad = 1'b0;
      for (int s = 0; s < NSIG; s++)
         for (int t = s + 1; t < NSIG; t++)
            if (slot_vld[s] && slot_vld[t] && (slot_pin[t] <= slot_pin[s]))
               order_bad = 1'b1;
   end

   // R8
   analog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ((pin_oe & $past(cfg_analog)) == '0));

   // R7
   odrain_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ((pin_out & $past(cfg_odrain)) == '0));

   // R1
   prio_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !order_bad);

   for (genvar s = 0; s < NSIG; s++) begin : g_slot
      // R3
      skip_honour_chk: assert property (@(posedge clk) disable iff (!rst_n)
         slot_vld[s] |-> !skip_q[slot_pin[s]]);
      // R4
      unplaced_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !slot_vld[s] |-> per_in[s]);
   end
endmodule

bind prio_xbar prio_xbar_chk #(.NPIN(NPIN), .NSIG(NSIG), .PW(PW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_odrain (cfg_odrain),
   .cfg_analog (cfg_analog),
   .pin_out    (pin_out),
   .pin_oe     (pin_oe),
   .per_in     (per_in),
   .skip_q     (skip_q),
   .slot_vld   (slot_vld),
   .slot_pin   (slot_pin)
);

// File: tb/sim_prio_xbar.sv
`timescale 1ns/1ps
module sim_prio_xbar;
   localparam int NPIN = 24;
   localparam int NPCA = 6;
   localparam int NSIG = 19;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0]      en_a = '0, en_b = '0;
   logic [NPIN-1:0] skip = '0, od = '0, ana = '0, lat = '1, pin_in = '0;
   logic [NSIG-1:0] pout = '0, poe = '0;
   logic [NSIG-1:0] per_in;
   logic [NPIN-1:0] pin_out, pin_oe, port_rd;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int exp_pin[NSIG];
   int owner[NPIN];

   always #2.5 clk = ~clk;

   prio_xbar u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_en_a(en_a), .cfg_en_b(en_b), .cfg_skip(skip),
      .cfg_odrain(od), .cfg_analog(ana), .cfg_latch(lat),
      .per_out(pout), .per_oe(poe), .per_in(per_in),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .port_rd(port_rd)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit slot_on(int s);
      int cnt;
      cnt = (int'(en_b[2:0]) > NPCA) ? NPCA : int'(en_b[2:0]);
      if (s < 2)  return en_a[0];
      if (s < 6)  return en_a[1];
      if (s < 8)  return en_a[2];
      if (s == 8) return en_a[3];
      if (s == 9) return en_a[4];
      if (s == 10) return en_a[5];
      if (s < 11 + NPCA) return (s - 11) < cnt;
      if (s == 11 + NPCA) return en_b[3];
      return en_b[4];
   endfunction

   // sequential scan model
   task automatic build_map();
      int ptr;
      ptr = 0;
      for (int p = 0; p < NPIN; p++) owner[p] = -1;
      for (int s = 0; s < NSIG; s++) begin
         exp_pin[s] = -1;
         if (slot_on(s)) begin
            while (ptr < NPIN && skip[ptr]) ptr++;
            if (ptr < NPIN) begin
               exp_pin[s] = ptr;
               owner[ptr] = s;
               ptr++;
            end
         end
      end
   endtask

   task automatic check_all(string tag);
      logic [NPIN-1:0] eo, ee;
      logic [NSIG-1:0] ei;
      build_map();
      for (int p = 0; p < NPIN; p++) begin
         logic v, e;
         if (owner[p] >= 0) begin v = pout[owner[p]]; e = poe[owner[p]]; end
         else begin v = lat[p]; e = 1'b1; end
         eo[p] = od[p] ? 1'b0 : v;
         ee[p] = ana[p] ? 1'b0 : (od[p] ? (e & ~v) : e);
      end
      for (int s = 0; s < NSIG; s++)
         ei[s] = (exp_pin[s] >= 0) ? pin_in[exp_pin[s]] : 1'b1;
      chk({tag, " R5/R6/R7 pin_out"}, 32'(pin_out), 32'(eo));
      chk({tag, " R5/R6/R7/R8 pin_oe"}, 32'(pin_oe), 32'(ee));
      chk({tag, " R1/R2/R3/R4/R5 per_in"}, 32'(per_in), 32'(ei));
   endtask

   task automatic apply_and_check(string tag);
      @(posedge clk);
      #1;
      check_all(tag);
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 pin_out", 32'(pin_out), 32'hFFFFFF);
      chk("R11 pin_oe", 32'(pin_oe), 32'hFFFFFF);
      chk("R11 per_in", 32'(per_in), 32'h7FFFF);
      chk("R11 port_rd", 32'(port_rd), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 latency: UART on, TX low -> pin 0 only after the edge
      en_a = 8'h01; pout = '0; poe = '1;
      #1;
      chk("R10 before edge", 32'(pin_out[0]), 32'h1);
      @(posedge clk); #1;
      chk("R10 after edge", 32'(pin_out[0]), 32'h0);
      @(negedge clk);

      // R1 R2 everything enabled, no skips; PCA count 7 clamps to 6
      en_a = 8'hFF; en_b = 8'hFF; skip = '0;
      pout = 19'h2A5C3; poe = 19'h7F0F1; pin_in = 24'hA5C33C;
      apply_and_check("R1 R2 full");

      // R3 R4 skip all but three pins
      skip = ~24'h800401;
      apply_and_check("R3 R4 sparse");

      // R3 all skipped: pure GPIO
      skip = '1; lat = 24'h5A5A5A;
      apply_and_check("R3 R6 all skipped");

      // R8 analog everywhere with open-drain mixed
      skip = 24'h00F00F; ana = '1; od = 24'h0F0F0F;
      apply_and_check("R8 all analog");

      // R7 open-drain with latch pattern
      ana = '0; od = '1; en_a = '0; en_b = '0; lat = 24'hC3A50F;
      apply_and_check("R7 open drain");

      // R2 reserved bits alone have no effect
      od = '0; en_a = 8'hC0; en_b = 8'hE0; lat = 24'h123456;
      apply_and_check("R2 reserved bits");

      // random mix
      for (int i = 0; i < 300; i++) begin
         en_a = 8'($urandom); en_b = 8'($urandom);
         skip = 24'($urandom) & 24'($urandom);
         od = 24'($urandom); ana = 24'($urandom) & 24'($urandom) & 24'($urandom);
         lat = 24'($urandom); pin_in = 24'($urandom);
         pout = 19'($urandom); poe = 19'($urandom);
         apply_and_check("R1 R5 random");
      end

      // R9 read-back with stable pins, independent of config
      pin_in = 24'h3C5AA5; ana = '1; skip = '1;
      repeat (3) @(negedge clk);
      chk("R9 settled", 32'(port_rd), 32'h3C5AA5);
      pin_in = 24'hC3A55A;
      @(posedge clk); #1;
      chk("R9 one edge", 32'(port_rd), 32'h3C5AA5);
      @(posedge clk); #1;
      chk("R9 two edges", 32'(port_rd), 32'hC3A55A);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule